// File: doc/BRIEF.md
# Four-Operand Carry-Save Adder

This block adds four unsigned operands of equal width and returns their exact total. Rather than chaining three full-width adders, it first collapses the operands through two rows of independent 3:2 compressors. Each row produces a sum vector and a carry vector without any carry travelling from one bit position to the next. One ripple adder at the end then joins the last sum and carry vectors into a plain binary result.

The block is purely combinational: no clock and no reset. It suits datapaths that need a wide sum of several terms, such as accumulating partial products or adding filter taps. The output is two bits wider than the operands, so no input combination can lose a bit.

Top module: `csa4_adder`

## Requirements
- R1: The output `total` equals the unsigned arithmetic sum a + b + c + d, expressed in OP_W+2 bits, for every operand combination.
- R2: The first compressor row takes a, b and c. At every bit it produces a sum bit, the exclusive-or of the three inputs, and a carry bit, true when at least two of the three inputs are set. Its sum plus twice its carry equals a + b + c.
- R3: A carry vector counts at twice the weight of the sum vector beside it. Before the next addition it is moved up one position, with 0 entering the lowest bit.
- R4: The second compressor row takes the first row's sum vector, the first row's moved-up carry vector and d. Its sum plus twice its carry equals the total of those three inputs.
- R5: The final ripple adder gives the exact sum of its two inputs and never carries out of the OP_W+2 bit result, even when all four operands are all ones (4 x 255 = 1020 at OP_W = 8).
- R6: All operands zero gives a total of zero.
- R7: Two operands 0110 and 0011 with the others zero give 1001. The first row yields sum vector 0101 and moved-up carry vector 00100.
- R8: The output depends only on the present operands: the same operands always give the same total, whatever operands came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | OP_W | First unsigned operand |
| b | input | OP_W | Second unsigned operand |
| c | input | OP_W | Third unsigned operand |
| d | input | OP_W | Fourth unsigned operand |
| total | output | OP_W+2 | Unsigned sum of the four operands |

## Verification
Every result is due in the same cycle as its operands: no register lies between inputs and `total`. The bench changes operands on a rising edge of its own clock and reads `total` on the next falling edge, half a period later, once the logic has settled. The bench compares each value with a sum it computes in plain integer arithmetic. A sweep over every pair of values for a and b, with c and d derived from them, covers carries entering every position of both rows. Repeated operand sets in a different order check that no earlier stimulus leaves a trace.

// File: rtl/csa4_pkg.sv
package csa4_pkg;

  // One-bit full adder: sum output (parity of the three inputs)
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // One-bit full adder: carry output (majority of the three inputs)
  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/csa_row.sv
module csa_row
  import csa4_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic [ROW_W-1:0] in_x,
  input  logic [ROW_W-1:0] in_y,
  input  logic [ROW_W-1:0] in_z,
  output logic [ROW_W-1:0] sum_v,
  output logic [ROW_W-1:0] cry_v
);

  // Independent full adders, no ripple between bit positions
  for (genvar i = 0; i < ROW_W; i++) begin : g_bit
    assign sum_v[i] = fa_sum(in_x[i], in_y[i], in_z[i]);
    assign cry_v[i] = fa_carry(in_x[i], in_y[i], in_z[i]);
  end

  // Value preserved by the row: the sum plus twice the carry equals the three inputs (R2, R4)
  localparam int CHK_W = ROW_W + 2;
  logic [CHK_W-1:0] in_total;
  logic [CHK_W-1:0] out_total;
  assign in_total  = CHK_W'(in_x) + CHK_W'(in_y) + CHK_W'(in_z);
  assign out_total = CHK_W'(sum_v) + (CHK_W'(cry_v) << 1);

  always_comb begin
    if (!$isunknown({in_x, in_y, in_z})) begin
      // R2
      row_value_chk: assert (in_total == out_total);
    end
  end

endmodule

// File: rtl/ripple_merge.sv
module ripple_merge
  import csa4_pkg::*;
#(
  parameter int ADD_W = 10
) (
  input  logic [ADD_W-1:0] op_s,
  input  logic [ADD_W-1:0] op_c,
  output logic [ADD_W-1:0] res,
  output logic             cout
);

  logic [ADD_W:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < ADD_W; i++) begin : g_stage
    assign res[i]     = fa_sum(op_s[i], op_c[i], chain[i]);
    assign chain[i+1] = fa_carry(op_s[i], op_c[i], chain[i]);
  end

  assign cout = chain[ADD_W];

  logic [ADD_W:0] ref_total;
  assign ref_total = (ADD_W+1)'(op_s) + (ADD_W+1)'(op_c);

  always_comb begin
    if (!$isunknown({op_s, op_c})) begin
      // R5
      merge_exact_chk: assert ({cout, res} == ref_total);
    end
  end

endmodule

// File: rtl/csa4_adder.sv
module csa4_adder
  import csa4_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic [OP_W-1:0]   c,
  input  logic [OP_W-1:0]   d,
  output logic [OP_W+1:0]   total
);

  localparam int ROW2_W = OP_W + 1;
  localparam int OUT_W  = OP_W + 2;

  // First row: a, b, c
  logic [OP_W-1:0] s1;
  logic [OP_W-1:0] k1;

  csa_row #(.ROW_W(OP_W)) row1_i (
    .in_x  (a),
    .in_y  (b),
    .in_z  (c),
    .sum_v (s1),
    .cry_v (k1)
  );

  // Carry counts double: move up one place, zero enters at the bottom (R3)
  logic [ROW2_W-1:0] k1_up;
  assign k1_up = {k1, 1'b0};

  // Second row: first-row sum, moved-up carry, d (R4)
  logic [ROW2_W-1:0] s2;
  logic [ROW2_W-1:0] k2;

  csa_row #(.ROW_W(ROW2_W)) row2_i (
    .in_x  ({1'b0, s1}),
    .in_y  (k1_up),
    .in_z  ({1'b0, d}),
    .sum_v (s2),
    .cry_v (k2)
  );

  // Single carry-propagate merge
  logic [OUT_W-1:0] merged;
  logic             spill;

  ripple_merge #(.ADD_W(OUT_W)) merge_i (
    .op_s ({1'b0, s2}),
    .op_c ({k2, 1'b0}),
    .res  (merged),
    .cout (spill)
  );

  assign total = merged;

  logic [OUT_W-1:0] direct_sum;
  assign direct_sum = OUT_W'(a) + OUT_W'(b) + OUT_W'(c) + OUT_W'(d);

  always_comb begin
    if (!$isunknown({a, b, c, d})) begin
      // R5
      no_overflow_chk: assert (!spill);
      // R1
      total_sum_chk: assert (total == direct_sum);
      // R3
      carry_top_clear_chk: assert (!k2[ROW2_W-1]);
    end
  end

endmodule

// File: tb/csa4_adder_tb.sv
module csa4_adder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OP_W       = 8;
  localparam int OUT_W      = OP_W + 2;

  logic             clk;
  logic [OP_W-1:0]  a, b, c, d;
  logic [OUT_W-1:0] total;

  int n_checks = 0;
  int n_errors = 0;

  csa4_adder #(.OP_W(OP_W)) dut_i (
    .a     (a),
    .b     (b),
    .c     (c),
    .d     (d),
    .total (total)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic apply_and_check(input logic [OP_W-1:0] va, input logic [OP_W-1:0] vb,
                                 input logic [OP_W-1:0] vc, input logic [OP_W-1:0] vd,
                                 input string req);
    int expv;
    @(posedge clk);
    a = va; b = vb; c = vc; d = vd;
    expv = int'(va) + int'(vb) + int'(vc) + int'(vd);
    @(negedge clk);
    n_checks++;
    if (int'(total) != expv) begin
      n_errors++;
      $display("FAIL %s: a=%0d b=%0d c=%0d d=%0d total=%0d expected=%0d",
               req, va, vb, vc, vd, total, expv);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: run did not end, total=%0d expected=done", total);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    a = '0; b = '0; c = '0; d = '0;
    // R6: zero operands give zero
    apply_and_check(8'd0, 8'd0, 8'd0, 8'd0, "R6");
    // R7: 0110 + 0011 gives 1001
    apply_and_check(8'd6, 8'd3, 8'd0, 8'd0, "R7");
    // R5: all ones, largest total 1020
    apply_and_check(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R5");
    // R2: first row alone, d zero
    apply_and_check(8'hAA, 8'h55, 8'hFF, 8'h00, "R2");
    apply_and_check(8'hF0, 8'h0F, 8'h3C, 8'h00, "R2");
    // R3: every first-row carry set, moved to the next weight
    apply_and_check(8'hFF, 8'hFF, 8'h00, 8'h00, "R3");
    apply_and_check(8'h80, 8'h80, 8'h80, 8'h00, "R3");
    // R4: d combined with first-row results
    apply_and_check(8'h7F, 8'h01, 8'h80, 8'hFF, "R4");
    apply_and_check(8'h00, 8'h00, 8'h00, 8'hFF, "R4");
    // R8: same operands after different history give the same total
    apply_and_check(8'h12, 8'h34, 8'h56, 8'h78, "R8");
    apply_and_check(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R8");
    apply_and_check(8'h12, 8'h34, 8'h56, 8'h78, "R8");
    apply_and_check(8'h00, 8'h00, 8'h00, 8'h00, "R8");
    apply_and_check(8'h12, 8'h34, 8'h56, 8'h78, "R8");
    // R1: full sweep of a and b, c and d derived from them
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        apply_and_check(8'(ia), 8'(ib), ~8'(ia), 8'(ia) ^ 8'(ib), "R1");
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule